// File: doc/BRIEF.md
# Allocation Tag Generator with Exclusion Mask

This unit produces 4-bit memory allocation tags. It has two kinds of request. A random request draws a tag from a 16-bit linear feedback seed register. A derive request takes a start tag and a 4-bit offset and walks forward through the tag space. During that walk it steps over every tag value that a 16-bit exclusion mask forbids.

Software can load the seed register through a write port while the unit is idle, and can read it back at any time. The seed value carries across requests, so successive random tags continue one sequence. A request is accepted with a single-cycle start strobe while the unit is idle. The unit then reports busy and advances one step per clock. When it finishes, it raises done for one cycle together with the result, and the result stays on the tag output until the next request completes.

Top module: `tag_gen_top`

## Requirements
- R1: After reset, the seed reads 16'hACE1, busy and done are low, and the tag output is 0.
- R2: When the unit is idle and seed_wr is high, the seed takes seed_wdata at that edge and reads back on the next cycle.
- R3: A seed write issued while busy has no effect: the seed readback after the request matches the value it would have had without the write.
- R4: A random request (req_kind = 0) produces four bits in turn. Each bit is the XOR of seed bits 5, 3, 2 and 0. After each bit the seed shifts right by one, with the new bit entering at bit 15. The first bit becomes tag bit 0 and the fourth becomes tag bit 3.
- R5: Consecutive random requests continue the same seed sequence, and the seed readback after each request equals four shifts of the seed it started from.
- R6: For a derive request (req_kind = 1) with an all-ones mask, the start tag is returned with done high on the cycle right after acceptance.
- R7: For a derive request with offset 0, the start tag is returned if its mask bit is 0. Otherwise the tag is incremented until it reaches a value whose mask bit (bit i stands for tag value i) is 0.
- R8: For a derive request with nonzero offset, the following is done once per unit of offset: increment the tag once, then keep incrementing past excluded values. The value reached at the end is returned.
- R9: Tag increments wrap from 15 to 0.
- R10: Done is high for exactly one cycle per completed request, never together with busy, and the tag output holds the result until the next completion.
- R11: A start strobe that arrives while busy is ignored: it neither changes the running result nor produces an extra completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_wr | input | 1 | Seed load strobe, honoured only when idle |
| seed_wdata | input | 16 | Seed load value |
| seed_rdata | output | 16 | Current seed register contents |
| req_start | input | 1 | Request strobe, honoured only when idle |
| req_kind | input | 1 | 0 = random tag, 1 = derive from start and offset |
| start_tag | input | 4 | Start tag for a derive request |
| tag_offset | input | 4 | Offset for a derive request |
| excl_mask | input | 16 | Bit i set forbids tag value i |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| tag_out | output | 4 | Result of the latest completed request |

## Verification
The bench targets masks that force a wrap from 15 to 0, and a mask that leaves only one value allowed while using the maximum offset. A walker that failed to wrap or skipped the wrong value would return a neighbouring tag there. It also checks that with offset 0 an allowed start value is returned unchanged and an excluded one is moved, and that with a nonzero offset the start value is always left. A design that reversed these would differ from the model by at least one step. The full-mask case is timed to the cycle, because a design that searched anyway would hang or come back late. During a long derive request, the bench sends a stray strobe and a seed write. A design that obeyed either would change the seed readback or produce a done pulse that nothing expects.

// File: rtl/tag_gen_pkg.sv
package tag_gen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RAND = 2'd1,
        ST_ADV  = 2'd2,
        ST_SKIP = 2'd3
    } tg_state_e;

    typedef enum logic {
        KIND_RANDOM = 1'b0,
        KIND_DERIVE = 1'b1
    } tg_kind_e;

endpackage

// File: rtl/tag_lfsr_step.sv
module tag_lfsr_step #(
    parameter int unsigned          SEED_W = 16,
    parameter logic [SEED_W-1:0]    TAPS   = 16'h002D
) (
    input  logic [SEED_W-1:0] seed_i,
    output logic              bit_o,
    output logic [SEED_W-1:0] seed_o
);
    logic [SEED_W-1:0] chain;

    assign chain[0] = TAPS[0] & seed_i[0];

    genvar gi;
    generate
        for (gi = 1; gi < SEED_W; gi++) begin : g_tap
            assign chain[gi] = chain[gi-1] ^ (TAPS[gi] & seed_i[gi]);
        end
    endgenerate

    assign bit_o  = chain[SEED_W-1];
    assign seed_o = {bit_o, seed_i[SEED_W-1:1]};
endmodule

// File: rtl/tag_skip_step.sv
module tag_skip_step #(
    parameter int unsigned TAG_W = 4,
    localparam int unsigned TAG_N = 1 << TAG_W
) (
    input  logic [TAG_W-1:0] tag_i,
    input  logic [TAG_N-1:0] mask_i,
    output logic             excluded_o,
    output logic [TAG_W-1:0] tag_inc_o
);
    assign excluded_o = mask_i[tag_i];
    assign tag_inc_o  = tag_i + 1'b1;
endmodule

// File: rtl/tag_mask_full.sv
module tag_mask_full #(
    parameter int unsigned N = 16
) (
    input  logic [N-1:0] mask_i,
    output logic         full_o
);
    assign full_o = &mask_i;
endmodule

// File: rtl/tag_gen_top.sv
module tag_gen_top
    import tag_gen_pkg::*;
#(
    parameter int unsigned          SEED_W     = 16,
    parameter int unsigned          TAG_W      = 4,
    parameter logic [SEED_W-1:0]    SEED_TAPS  = 16'h002D,
    parameter logic [SEED_W-1:0]    SEED_RESET = 16'hACE1,
    localparam int unsigned         TAG_N      = 1 << TAG_W,
    localparam int unsigned         BIT_CW     = (TAG_W > 1) ? $clog2(TAG_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_wr,
    input  logic [SEED_W-1:0] seed_wdata,
    output logic [SEED_W-1:0] seed_rdata,
    input  logic              req_start,
    input  logic              req_kind,
    input  logic [TAG_W-1:0]  start_tag,
    input  logic [TAG_W-1:0]  tag_offset,
    input  logic [TAG_N-1:0]  excl_mask,
    output logic              busy,
    output logic              done,
    output logic [TAG_W-1:0]  tag_out
);
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(TAG_W - 1);

    typedef struct packed {
        tg_state_e          st;
        logic [SEED_W-1:0]  seed;
        logic [TAG_W-1:0]   tag;
        logic [TAG_W-1:0]   off;
        logic [TAG_N-1:0]   mask;
        logic [BIT_CW-1:0]  bitn;
        logic               done;
        logic [TAG_W-1:0]   res;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic              rnd_bit;
    logic [SEED_W-1:0] rnd_seed;
    logic              cur_excluded;
    logic [TAG_W-1:0]  cur_inc;
    logic              in_mask_full;

    tag_lfsr_step #(
        .SEED_W (SEED_W),
        .TAPS   (SEED_TAPS)
    ) i_lfsr (
        .seed_i (ctx_q.seed),
        .bit_o  (rnd_bit),
        .seed_o (rnd_seed)
    );

    tag_skip_step #(
        .TAG_W (TAG_W)
    ) i_skip (
        .tag_i      (ctx_q.tag),
        .mask_i     (ctx_q.mask),
        .excluded_o (cur_excluded),
        .tag_inc_o  (cur_inc)
    );

    tag_mask_full #(
        .N (TAG_N)
    ) i_full (
        .mask_i (excl_mask),
        .full_o (in_mask_full)
    );

    always_comb begin
        logic [TAG_W-1:0] rnd_tag;
        ctx_d      = ctx_q;
        ctx_d.done = 1'b0;
        rnd_tag    = ctx_q.tag;
        rnd_tag[ctx_q.bitn] = rnd_bit;

        unique case (ctx_q.st)
            ST_IDLE: begin
                if (seed_wr) begin
                    ctx_d.seed = seed_wdata;
                end
                if (req_start) begin
                    ctx_d.mask = excl_mask;
                    ctx_d.off  = tag_offset;
                    ctx_d.bitn = '0;
                    if (tg_kind_e'(req_kind) == KIND_RANDOM) begin
                        ctx_d.tag = '0;
                        ctx_d.st  = ST_RAND;
                    end else if (in_mask_full) begin
                        ctx_d.tag  = start_tag;
                        ctx_d.res  = start_tag;
                        ctx_d.done = 1'b1;
                    end else begin
                        ctx_d.tag = start_tag;
                        ctx_d.st  = (tag_offset == '0) ? ST_SKIP : ST_ADV;
                    end
                end
            end

            ST_RAND: begin
                ctx_d.seed = rnd_seed;
                ctx_d.tag  = rnd_tag;
                if (ctx_q.bitn == LAST_BIT) begin
                    ctx_d.res  = rnd_tag;
                    ctx_d.done = 1'b1;
                    ctx_d.st   = ST_IDLE;
                end else begin
                    ctx_d.bitn = ctx_q.bitn + 1'b1;
                end
            end

            ST_ADV: begin
                ctx_d.off = ctx_q.off - 1'b1;
                ctx_d.tag = cur_inc;
                ctx_d.st  = ST_SKIP;
            end

            ST_SKIP: begin
                if (cur_excluded) begin
                    ctx_d.tag = cur_inc;
                end else if (ctx_q.off == '0) begin
                    ctx_d.res  = ctx_q.tag;
                    ctx_d.done = 1'b1;
                    ctx_d.st   = ST_IDLE;
                end else begin
                    ctx_d.off = ctx_q.off - 1'b1;
                    ctx_d.tag = cur_inc;
                end
            end

            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q.st   <= ST_IDLE;
            ctx_q.seed <= SEED_RESET;
            ctx_q.tag  <= '0;
            ctx_q.off  <= '0;
            ctx_q.mask <= '0;
            ctx_q.bitn <= '0;
            ctx_q.done <= 1'b0;
            ctx_q.res  <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign seed_rdata = ctx_q.seed;
    assign busy       = (ctx_q.st != ST_IDLE);
    assign done       = ctx_q.done;
    assign tag_out    = ctx_q.res;
endmodule

// File: rtl/tag_gen_chk.sv
module tag_gen_chk #(
    parameter int unsigned SEED_W = 16,
    parameter int unsigned TAG_W  = 4,
    localparam int unsigned TAG_N = 1 << TAG_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              seed_wr,
    input logic [SEED_W-1:0] seed_wdata,
    input logic [SEED_W-1:0] seed_rdata,
    input logic              req_start,
    input logic              req_kind,
    input logic [TAG_W-1:0]  start_tag,
    input logic [TAG_N-1:0]  excl_mask,
    input logic              busy,
    input logic              done,
    input logic [TAG_W-1:0]  tag_out
);
    // R10
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R11
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) || $past(req_start)));

    // R11
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_start));

    // R6
    full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_start && !busy && req_kind && (excl_mask == '1))
        |=> (done && (tag_out == $past(start_tag))));

    // R4
    seed_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && (seed_rdata != $past(seed_rdata)))
        |-> (seed_rdata[SEED_W-2:0] == $past(seed_rdata[SEED_W-1:1])));

    // R2
    seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && seed_wr) |=> (seed_rdata == $past(seed_wdata)));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !$past(done)) |-> $stable(tag_out));
endmodule

bind tag_gen_top tag_gen_chk #(
    .SEED_W (SEED_W),
    .TAG_W  (TAG_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .seed_wr    (seed_wr),
    .seed_wdata (seed_wdata),
    .seed_rdata (seed_rdata),
    .req_start  (req_start),
    .req_kind   (req_kind),
    .start_tag  (start_tag),
    .excl_mask  (excl_mask),
    .busy       (busy),
    .done       (done),
    .tag_out    (tag_out)
);

// File: tb/test_tag_gen_top.sv
module test_tag_gen_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seed_wr = 1'b0;
    logic [15:0] seed_wdata = '0;
    logic [15:0] seed_rdata;
    logic        req_start = 1'b0;
    logic        req_kind = 1'b0;
    logic [3:0]  start_tag = '0;
    logic [3:0]  tag_offset = '0;
    logic [15:0] excl_mask = '0;
    logic        busy;
    logic        done;
    logic [3:0]  tag_out;

    int n_chk = 0;
    int n_fail = 0;
    int n_push = 0;
    int n_pop = 0;
    logic [3:0] exp_q[$];
    string      req_q[$];
    logic [15:0] model_seed;

    always #(CLK_PERIOD/2) clk = ~clk;

    tag_gen_top i_tag_gen_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .seed_wr    (seed_wr),
        .seed_wdata (seed_wdata),
        .seed_rdata (seed_rdata),
        .req_start  (req_start),
        .req_kind   (req_kind),
        .start_tag  (start_tag),
        .tag_offset (tag_offset),
        .excl_mask  (excl_mask),
        .busy       (busy),
        .done       (done),
        .tag_out    (tag_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] model_random(inout logic [15:0] s);
        logic [3:0] t;
        for (int i = 0; i < 4; i++) begin
            logic b;
            b = s[5] ^ s[3] ^ s[2] ^ s[0];
            s = {b, s[15:1]};
            t[i] = b;
        end
        return t;
    endfunction

    function automatic logic [3:0] model_derive(input logic [3:0] t, input logic [3:0] o,
                                                input logic [15:0] m);
        if (m == 16'hFFFF) return t;
        if (o == 4'd0) begin
            while (m[t]) t = t + 4'd1;
        end
        while (o != 4'd0) begin
            o = o - 4'd1;
            t = t + 4'd1;
            while (m[t]) t = t + 4'd1;
        end
        return t;
    endfunction

    // monitor: pops expected results as done pulses appear
    always @(negedge clk) begin
        if (rst_n && done) begin
            check(!busy, "R10 busy low with done", int'(busy), 0);
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected completion", int'(tag_out), -1);
            end else begin
                logic [3:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                n_pop++;
                check(tag_out == e, r, int'(tag_out), int'(e));
            end
        end
    end

    task automatic wait_drain();
        while (n_pop < n_push) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic kind, input logic [3:0] st, input logic [3:0] off,
                         input logic [15:0] m);
        @(negedge clk);
        req_start  = 1'b1;
        req_kind   = kind;
        start_tag  = st;
        tag_offset = off;
        excl_mask  = m;
        @(negedge clk);
        req_start  = 1'b0;
    endtask

    task automatic do_random(input string r);
        logic [3:0] e;
        e = model_random(model_seed);
        exp_q.push_back(e);
        req_q.push_back(r);
        n_push++;
        drive(1'b0, 4'd0, 4'd0, 16'h0);
        wait_drain();
        check(seed_rdata == model_seed, "R5 seed after random", int'(seed_rdata), int'(model_seed));
    endtask

    task automatic do_derive(input logic [3:0] st, input logic [3:0] off, input logic [15:0] m,
                             input string r);
        logic [3:0] e;
        e = model_derive(st, off, m);
        exp_q.push_back(e);
        req_q.push_back(r);
        n_push++;
        drive(1'b1, st, off, m);
        if (m == 16'hFFFF)
            check(done == 1'b1, "R6 done one cycle after accept", int'(done), 1);
        wait_drain();
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(seed_rdata == 16'hACE1, "R1 seed reset", int'(seed_rdata), 16'hACE1);
        check(busy == 1'b0, "R1 busy reset", int'(busy), 0);
        check(done == 1'b0, "R1 done reset", int'(done), 0);
        check(tag_out == 4'd0, "R1 tag reset", int'(tag_out), 0);
        model_seed = 16'hACE1;

        // R4 / R5 random sequence from reset seed
        for (int i = 0; i < 3; i++) do_random("R4 random tag");

        // R2 seed load and readback
        @(negedge clk);
        seed_wr = 1'b1; seed_wdata = 16'h1234;
        @(negedge clk);
        seed_wr = 1'b0;
        check(seed_rdata == 16'h1234, "R2 seed readback", int'(seed_rdata), 16'h1234);
        model_seed = 16'h1234;
        for (int i = 0; i < 5; i++) do_random("R5 random continued");

        // R6 full mask
        do_derive(4'd7, 4'd5, 16'hFFFF, "R6 full mask");
        do_derive(4'd0, 4'd0, 16'hFFFF, "R6 full mask zero");
        // R7 zero offset
        do_derive(4'd3, 4'd0, 16'h0000, "R7 allowed start kept");
        do_derive(4'd5, 4'd0, 16'h0060, "R7 excluded start moved");
        // R9 wrap
        do_derive(4'd14, 4'd0, 16'hC001, "R9 wrap zero offset");
        do_derive(4'd15, 4'd2, 16'h0002, "R9 wrap with offset");
        // R8 nonzero offset
        do_derive(4'd2, 4'd3, 16'h0000, "R8 plain offset");
        do_derive(4'd2, 4'd3, 16'h0018, "R8 offset with skips");
        do_derive(4'd4, 4'd1, 16'h0000, "R8 excluded-free start left");
        do_derive(4'd0, 4'd15, 16'h7FFF, "R8 single allowed value");
        do_derive(4'd9, 4'd15, 16'h5555, "R8 odd values only");
        for (int k = 0; k < 12; k++)
            do_derive(4'(k * 5), 4'(k), 16'(16'h8421 << (k % 4)) ^ 16'(k * 16'h0101),
                      "R8 pattern sweep");

        // R3 / R11 stray strobe and seed write while busy
        exp_q.push_back(model_derive(4'd0, 4'd15, 16'h7FFF));
        req_q.push_back("R11 running result kept");
        n_push++;
        drive(1'b1, 4'd0, 4'd15, 16'h7FFF);
        repeat (3) @(negedge clk);
        seed_wr = 1'b1; seed_wdata = 16'hBEEF;
        req_start = 1'b1; req_kind = 1'b0; excl_mask = 16'h0;
        @(negedge clk);
        seed_wr = 1'b0; req_start = 1'b0;
        wait_drain();
        repeat (10) @(negedge clk);
        check(seed_rdata == model_seed, "R3 seed write while busy", int'(seed_rdata), int'(model_seed));
        check(n_pop == n_push, "R11 completion count", n_pop, n_push);

        // R10 result held while idle
        check(tag_out == 4'd15, "R10 result held", int'(tag_out), 15);
        do_random("R5 random after ignored write");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule